// File: doc/BRIEF.md
# Table Access Memory Protection Unit

This unit sits between a processor's table-read and table-write ports and a 64 KB program flash. Each access brings a table pointer, the address of the instruction that issues it and a read or write strobe. The unit maps both addresses onto protection regions and decides whether the access reaches the flash. A permitted write goes to the flash write strobe. A denied write is dropped and flagged for one cycle. A permitted read returns flash data one cycle after the strobe. A denied read does not fault: it returns zeros.

The unit also holds three protection bits per region: write-enable, read-open and external-access. Software can clear these bits through a configuration write but can never set them. Only the two erase commands from the separate programming input set them again: a full-chip erase sets every region, and a region erase sets one region. The external-access bits do not affect table accesses. They only gate requests from the external programming side.

Top module: `tblprot_unit`

## Requirements
- R1: The region map for table pointers and instruction addresses is as follows. Region index 0 is 0x000000–0x0007FF. Indices 1 to 4 are 0x000800–0x003FFF, 0x004000–0x007FFF, 0x008000–0x00BFFF and 0x00C000–0x00FFFF. Any address at or above 0x010000 lies in no region.
- R2: When the write-enable bit of the target region is 0, a table write is denied whatever the instruction address: `tb_wr_ok` is 0 and `fl_wr_en` stays low. When the bit is 1, `tb_wr_ok` and `fl_wr_en` follow `tb_wr`.
- R3: When the read-open bit of the target region is 1, a table read is allowed. When it is 0, the read is allowed only if the instruction address lies in the same region. An instruction address outside every region never matches.
- R4: The cycle after a read strobe, `tb_rd_data` carries the flash word for an allowed read and all zeros for a denied one. No other signal reports the denial.
- R5: A configuration write sets each protection bit to the old bit AND the written bit, so writing a 1 over a 0 has no effect. The `cfg_wdata` and `cfg_q` layout is: bits [4:0] are the write-enable bits of regions 0..4, bits [9:5] the read-open bits, and bits [14:10] the external-access bits.
- R6: `ers_chip` sets all 15 bits to 1. `ers_blk` sets the three bits of region `ers_idx` and leaves the other regions alone. An `ers_idx` of 5 or more changes nothing. In the same cycle, an erase takes precedence over a configuration write for the regions it sets.
- R7: The external-access bits have no effect on table reads or writes. `ext_rd_ok` and `ext_wr_ok` follow `ext_rd` and `ext_wr` combinationally. They are forced to 0 when `ext_addr` lies in a region whose external-access bit is 0, and they pass for addresses outside every region.
- R8: A denied table write raises `wr_err` for exactly the one cycle after its strobe.
- R9: A table read or write whose pointer is at or above 0x010000 is always allowed, whatever the protection bits.
- R10: After reset, all protection bits are 1, `tb_rd_data` is zero and `wr_err` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tb_rd | input | 1 | Table read strobe |
| tb_wr | input | 1 | Table write strobe |
| tb_addr | input | 24 | Table pointer |
| pc_addr | input | 24 | Address of the executing instruction |
| tb_wdata | input | 8 | Table write data |
| tb_rd_data | output | 8 | Read data, one cycle after the strobe, zero if denied |
| tb_rd_ok | output | 1 | Combinational read permission |
| tb_wr_ok | output | 1 | Combinational write permission |
| wr_err | output | 1 | One-cycle pulse after a denied write |
| fl_addr | output | 24 | Flash address |
| fl_rd_en | output | 1 | Flash read strobe (allowed reads only) |
| fl_wr_en | output | 1 | Flash write strobe (allowed writes only) |
| fl_wdata | output | 8 | Flash write data |
| fl_rdata | input | 8 | Flash read data, valid the cycle after `fl_rd_en` |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 15 | Configuration write word (layout in R5) |
| cfg_q | output | 15 | Current protection bits (layout in R5) |
| ers_chip | input | 1 | Full-chip erase command |
| ers_blk | input | 1 | Region erase command |
| ers_idx | input | 3 | Region index for a region erase |
| ext_addr | input | 24 | External request address |
| ext_rd | input | 1 | External read request |
| ext_wr | input | 1 | External write request |
| ext_rd_ok | output | 1 | External read granted |
| ext_wr_ok | output | 1 | External write granted |

## Verification
A wrong protection bit shows on `cfg_q` in the cycle after the configuration write or erase that produced it. It also shows at once on `tb_rd_ok` or `tb_wr_ok` for any pointer in that region. A faulty region decode shows only for pointers near a region edge, so the bench probes both ends of every region under all 32 patterns of clear and set bits, from instruction addresses in every region. A stale permission register shows as a nonzero `tb_rd_data`, or a `wr_err` that is missing or too long, one cycle after the access.

// File: rtl/tblprot_pkg.sv
package tblprot_pkg;
  localparam int REGION_IDX_W = 8;

  typedef struct packed {
    logic                    hit;
    logic [REGION_IDX_W-1:0] idx;
  } region_t;
endpackage

// File: rtl/tp_region_dec.sv
module tp_region_dec
  import tblprot_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int BOOT_SZ = 2048,
  parameter int BLK_SZ  = 16384,
  parameter int NUM_BLK = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output region_t           reg_o
);
  localparam int BLK_LG = $clog2(BLK_SZ);
  localparam logic [ADDR_W:0] BOOT_LIM = (ADDR_W+1)'(BOOT_SZ);
  localparam logic [ADDR_W:0] TOP_LIM  = (ADDR_W+1)'(BLK_SZ * NUM_BLK);

  logic [ADDR_W:0] addr_x;

  always_comb begin
    addr_x    = {1'b0, addr};
    reg_o.hit = 1'b0;
    reg_o.idx = '0;
    if (addr_x < BOOT_LIM) begin
      reg_o.hit = 1'b1;
    end else if (addr_x < TOP_LIM) begin
      reg_o.hit = 1'b1;
      reg_o.idx = REGION_IDX_W'(addr >> BLK_LG) + REGION_IDX_W'(1);
    end
  end
endmodule

// File: rtl/tp_cfg_bits.sv
module tp_cfg_bits #(
  parameter int NREG  = 5,
  parameter int IDX_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [3*NREG-1:0] cfg_wdata,
  input  logic              ers_chip,
  input  logic              ers_blk,
  input  logic [IDX_W-1:0]  ers_idx,
  output logic [NREG-1:0]   wrt_o,
  output logic [NREG-1:0]   rdp_o,
  output logic [NREG-1:0]   cp_o
);
  logic [3*NREG-1:0] all_q;

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic [2:0] bits_q;
    logic [2:0] bits_d;
    logic       set_r;
    logic       en_r;

    always_comb begin
      set_r  = ers_chip | (ers_blk & (ers_idx == IDX_W'(r)));
      en_r   = set_r | cfg_we;
      bits_d = bits_q;
      if (set_r) begin
        bits_d = 3'b111;
      end else if (cfg_we) begin
        bits_d = bits_q & {cfg_wdata[2*NREG+r], cfg_wdata[NREG+r], cfg_wdata[r]};
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bits_q <= 3'b111;
      end else if (en_r) begin
        bits_q <= bits_d;
      end
    end

    assign wrt_o[r] = bits_q[0];
    assign rdp_o[r] = bits_q[1];
    assign cp_o[r]  = bits_q[2];
  end

  assign all_q = {cp_o, rdp_o, wrt_o};

  // R5: without an erase no bit may go from 0 to 1
  assert_no_set_without_erase_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ers_chip && !ers_blk) |=> ((all_q & ~$past(all_q)) == '0));

  // R6: a full-chip erase leaves every bit at 1
  assert_chip_erase_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ers_chip |=> (&all_q));
endmodule

// File: rtl/tp_access_gate.sv
module tp_access_gate
  import tblprot_pkg::*;
#(
  parameter int NREG   = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tb_rd,
  input  logic              tb_wr,
  input  region_t           tgt,
  input  region_t           pc,
  input  logic [NREG-1:0]   wrt,
  input  logic [NREG-1:0]   rdp,
  input  logic [DATA_W-1:0] fl_rdata,
  output logic              rd_ok,
  output logic              wr_ok,
  output logic              fl_rd_en,
  output logic              fl_wr_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              wr_err
);
  logic wbit;
  logic rbit;
  logic same_blk;
  logic rd_ok_q, rd_ok_d, rd_en;
  logic err_q, err_d;

  always_comb begin
    wbit = 1'b1;
    rbit = 1'b1;
    for (int r = 0; r < NREG; r++) begin
      if (tgt.idx == REGION_IDX_W'(r)) begin
        wbit = wrt[r];
        rbit = rdp[r];
      end
    end
    same_blk = pc.hit && (pc.idx == tgt.idx);
    rd_ok    = !tgt.hit || rbit || same_blk;
    wr_ok    = !tgt.hit || wbit;
    fl_rd_en = tb_rd & rd_ok;
    fl_wr_en = tb_wr & wr_ok;
  end

  // next-state
  always_comb begin
    rd_en   = tb_rd;
    rd_ok_d = rd_ok;
    err_d   = tb_wr & ~wr_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ok_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (rd_en) begin
        rd_ok_q <= rd_ok_d;
      end
      err_q <= err_d;
    end
  end

  assign rd_data = rd_ok_q ? fl_rdata : '0;
  assign wr_err  = err_q;

  // R4: a denied read returns zeros one cycle later
  assert_blocked_read_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tb_rd && !fl_rd_en) |=> (rd_data == '0));

  // R8: a write that never reached the flash is flagged next cycle
  assert_denied_write_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tb_wr && !fl_wr_en) |=> wr_err);

  // R8: no flag without a write strobe in the cycle before
  assert_flag_needs_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !tb_wr |=> !wr_err);
endmodule

// File: rtl/tblprot_unit.sv
module tblprot_unit
  import tblprot_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int DATA_W  = 8,
  parameter int BOOT_SZ = 2048,
  parameter int BLK_SZ  = 16384,
  parameter int NUM_BLK = 4,
  localparam int NREG   = NUM_BLK + 1,
  localparam int IDX_W  = $clog2(NREG),
  localparam int CFG_W  = 3 * NREG
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tb_rd,
  input  logic              tb_wr,
  input  logic [ADDR_W-1:0] tb_addr,
  input  logic [ADDR_W-1:0] pc_addr,
  input  logic [DATA_W-1:0] tb_wdata,
  output logic [DATA_W-1:0] tb_rd_data,
  output logic              tb_rd_ok,
  output logic              tb_wr_ok,
  output logic              wr_err,
  output logic [ADDR_W-1:0] fl_addr,
  output logic              fl_rd_en,
  output logic              fl_wr_en,
  output logic [DATA_W-1:0] fl_wdata,
  input  logic [DATA_W-1:0] fl_rdata,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_q,
  input  logic              ers_chip,
  input  logic              ers_blk,
  input  logic [IDX_W-1:0]  ers_idx,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              ext_rd,
  input  logic              ext_wr,
  output logic              ext_rd_ok,
  output logic              ext_wr_ok
);
  localparam logic [ADDR_W:0] BOOT_LIM = (ADDR_W+1)'(BOOT_SZ);

  logic [1:0]      rs_q;
  logic            rst_sync;
  region_t         tgt_reg, pc_reg, ext_reg;
  logic [NREG-1:0] wrt, rdp, cp;
  logic            ext_bit;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= 2'b00;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end
  assign rst_sync = rs_q[1];

  tp_region_dec #(.ADDR_W(ADDR_W), .BOOT_SZ(BOOT_SZ), .BLK_SZ(BLK_SZ), .NUM_BLK(NUM_BLK))
    u_dec_tgt (.addr(tb_addr), .reg_o(tgt_reg));
  tp_region_dec #(.ADDR_W(ADDR_W), .BOOT_SZ(BOOT_SZ), .BLK_SZ(BLK_SZ), .NUM_BLK(NUM_BLK))
    u_dec_pc (.addr(pc_addr), .reg_o(pc_reg));
  tp_region_dec #(.ADDR_W(ADDR_W), .BOOT_SZ(BOOT_SZ), .BLK_SZ(BLK_SZ), .NUM_BLK(NUM_BLK))
    u_dec_ext (.addr(ext_addr), .reg_o(ext_reg));

  tp_cfg_bits #(.NREG(NREG), .IDX_W(IDX_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_sync),
    .cfg_we   (cfg_we),
    .cfg_wdata(cfg_wdata),
    .ers_chip (ers_chip),
    .ers_blk  (ers_blk),
    .ers_idx  (ers_idx),
    .wrt_o    (wrt),
    .rdp_o    (rdp),
    .cp_o     (cp)
  );

  tp_access_gate #(.NREG(NREG), .DATA_W(DATA_W)) u_gate (
    .clk     (clk),
    .rst_n   (rst_sync),
    .tb_rd   (tb_rd),
    .tb_wr   (tb_wr),
    .tgt     (tgt_reg),
    .pc      (pc_reg),
    .wrt     (wrt),
    .rdp     (rdp),
    .fl_rdata(fl_rdata),
    .rd_ok   (tb_rd_ok),
    .wr_ok   (tb_wr_ok),
    .fl_rd_en(fl_rd_en),
    .fl_wr_en(fl_wr_en),
    .rd_data (tb_rd_data),
    .wr_err  (wr_err)
  );

  // external request gate: only the external-access bits apply here
  always_comb begin
    ext_bit = 1'b1;
    for (int r = 0; r < NREG; r++) begin
      if (ext_reg.hit && (ext_reg.idx == REGION_IDX_W'(r))) begin
        ext_bit = cp[r];
      end
    end
    ext_rd_ok = ext_rd & ext_bit;
    ext_wr_ok = ext_wr & ext_bit;
  end

  assign fl_addr  = tb_addr;
  assign fl_wdata = tb_wdata;
  assign cfg_q    = {cp, rdp, wrt};

  // R2: a write into region 0 with its write-enable bit cleared never reaches the flash
  assert_boot_write_guard_R2: assert property (@(posedge clk) disable iff (!rst_sync)
    (tb_wr && ({1'b0, tb_addr} < BOOT_LIM) && !cfg_q[0]) |-> !fl_wr_en);

  // R3: a read of a closed region 0 from outside it never reaches the flash
  assert_boot_read_guard_R3: assert property (@(posedge clk) disable iff (!rst_sync)
    (tb_rd && ({1'b0, tb_addr} < BOOT_LIM) && !cfg_q[NREG] &&
     !({1'b0, pc_addr} < BOOT_LIM)) |-> !fl_rd_en);

  // R7: a cleared external-access bit of region 0 blocks external reads there
  assert_ext_guard_R7: assert property (@(posedge clk) disable iff (!rst_sync)
    (ext_rd && ({1'b0, ext_addr} < BOOT_LIM) && !cfg_q[2*NREG]) |-> !ext_rd_ok);
endmodule

// File: tb/sim_tblprot_unit.sv
`timescale 1ns/1ps
module sim_tblprot_unit;
  localparam int NREG = 5;

  logic        clk;
  logic        rst_n;
  logic        tb_rd, tb_wr;
  logic [23:0] tb_addr, pc_addr;
  logic [7:0]  tb_wdata;
  logic [7:0]  tb_rd_data;
  logic        tb_rd_ok, tb_wr_ok, wr_err;
  logic [23:0] fl_addr;
  logic        fl_rd_en, fl_wr_en;
  logic [7:0]  fl_wdata;
  logic [7:0]  fl_rdata;
  logic        cfg_we;
  logic [14:0] cfg_wdata, cfg_q;
  logic        ers_chip, ers_blk;
  logic [2:0]  ers_idx;
  logic [23:0] ext_addr;
  logic        ext_rd, ext_wr, ext_rd_ok, ext_wr_ok;

  int checks = 0;
  int errors = 0;
  logic [14:0] exp_q;
  logic [23:0] rep_lo [6];
  logic [23:0] rep_hi [6];

  tblprot_unit u0 (
    .clk(clk), .rst_n(rst_n), .tb_rd(tb_rd), .tb_wr(tb_wr), .tb_addr(tb_addr),
    .pc_addr(pc_addr), .tb_wdata(tb_wdata), .tb_rd_data(tb_rd_data),
    .tb_rd_ok(tb_rd_ok), .tb_wr_ok(tb_wr_ok), .wr_err(wr_err), .fl_addr(fl_addr),
    .fl_rd_en(fl_rd_en), .fl_wr_en(fl_wr_en), .fl_wdata(fl_wdata), .fl_rdata(fl_rdata),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_q(cfg_q), .ers_chip(ers_chip),
    .ers_blk(ers_blk), .ers_idx(ers_idx), .ext_addr(ext_addr), .ext_rd(ext_rd),
    .ext_wr(ext_wr), .ext_rd_ok(ext_rd_ok), .ext_wr_ok(ext_wr_ok)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [7:0] pat(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'hA5;
  endfunction

  // synchronous-read flash model
  always @(posedge clk) begin
    if (fl_rd_en) fl_rdata <= pat(fl_addr);
  end

  function automatic int reg_of(input logic [23:0] a);
    if (a < 24'h000800) return 0;
    if (a < 24'h010000) return 1 + int'(a >> 14);
    return 5;
  endfunction

  function automatic logic [14:0] blk_mask(input int i);
    if (i >= NREG) return 15'h0;
    return (15'h1 << i) | (15'h1 << (i + NREG)) | (15'h1 << (i + 2*NREG));
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic erase_chip();
    @(negedge clk); ers_chip = 1'b1;
    @(negedge clk); ers_chip = 1'b0;
    exp_q = '1;
  endtask

  task automatic cfg_write(input logic [14:0] w);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = w;
    @(negedge clk); cfg_we = 1'b0;
    exp_q = exp_q & w;
  endtask

  task automatic access(input bit is_wr, input logic [23:0] a, input logic [23:0] pc);
    int  tr, pr;
    bit  ok;
    tr = reg_of(a);
    pr = reg_of(pc);
    @(negedge clk);
    tb_addr = a; pc_addr = pc; tb_wdata = a[7:0];
    if (is_wr) tb_wr = 1'b1; else tb_rd = 1'b1;
    #1;
    if (is_wr) begin
      ok = (tr == 5) || exp_q[tr];
      chk((tr == 5) ? "R9 write outside regions" : "R2 write permit (R1 map)", 32'(tb_wr_ok), 32'(ok));
      chk("R2 flash write strobe", 32'(fl_wr_en), 32'(ok));
    end else begin
      ok = (tr == 5) || exp_q[NREG + tr] || (tr == pr);
      chk((tr == 5) ? "R9 read outside regions" : "R3 read permit (R1 map)", 32'(tb_rd_ok), 32'(ok));
    end
    @(negedge clk);
    tb_rd = 1'b0; tb_wr = 1'b0;
    if (is_wr) chk("R8 error pulse", 32'(wr_err), 32'(!ok));
    else       chk("R4 read data", 32'(tb_rd_data), ok ? 32'(pat(a)) : 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rep_lo[0] = 24'h000000; rep_hi[0] = 24'h0007FF;
    rep_lo[1] = 24'h000800; rep_hi[1] = 24'h003FFF;
    rep_lo[2] = 24'h004000; rep_hi[2] = 24'h007FFF;
    rep_lo[3] = 24'h008000; rep_hi[3] = 24'h00BFFF;
    rep_lo[4] = 24'h00C000; rep_hi[4] = 24'h00FFFF;
    rep_lo[5] = 24'h010000; rep_hi[5] = 24'hFFFFFF;
    rst_n = 1'b0; tb_rd = 0; tb_wr = 0; tb_addr = 0; pc_addr = 0; tb_wdata = 0;
    cfg_we = 0; cfg_wdata = 0; ers_chip = 0; ers_blk = 0; ers_idx = 0;
    ext_addr = 0; ext_rd = 0; ext_wr = 0; fl_rdata = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    exp_q = '1;

    // R10 reset state
    chk("R10 cfg after reset", 32'(cfg_q), 32'h7FFF);
    chk("R10 read data after reset", 32'(tb_rd_data), 32'h0);
    chk("R10 error flag after reset", 32'(wr_err), 32'h0);

    // sweep every pattern of write-enable and read-open bits
    for (int m = 0; m < 32; m++) begin
      logic [4:0] rm, wm;
      rm = 5'(m);
      wm = {rm[0], rm[4:1]};
      erase_chip();
      cfg_write({5'h1F, ~rm, ~wm});
      chk("R5 cfg after clear write", 32'(cfg_q), 32'(exp_q));
      for (int t = 0; t < 6; t++) begin
        for (int p = 0; p < 6; p++) begin
          logic [23:0] pa;
          pa = p[0] ? rep_hi[p] : rep_lo[p];
          access(1'b0, rep_lo[t], pa);
          access(1'b0, rep_hi[t], pa);
          access(1'b1, (p[0] ? rep_hi[t] : rep_lo[t]), pa);
        end
      end
    end

    // R5 one-way bits
    erase_chip();
    cfg_write(15'h7FFE);
    chk("R5 write-enable of region 0 cleared", 32'(cfg_q), 32'h7FFE);
    cfg_write(15'h7FFF);
    chk("R5 writing 1 over 0 ignored", 32'(cfg_q), 32'h7FFE);
    access(1'b1, 24'h000123, 24'h000100);

    // R6 erases
    erase_chip();
    cfg_write(15'h0000);
    chk("R6 all cleared", 32'(cfg_q), 32'h0000);
    @(negedge clk); ers_blk = 1'b1; ers_idx = 3'd2;
    @(negedge clk); ers_blk = 1'b0;
    exp_q = exp_q | blk_mask(2);
    chk("R6 region erase sets one region", 32'(cfg_q), 32'(exp_q));
    @(negedge clk); ers_blk = 1'b1; ers_idx = 3'd7;
    @(negedge clk); ers_blk = 1'b0;
    chk("R6 region erase out of range", 32'(cfg_q), 32'(exp_q));
    erase_chip();
    chk("R6 chip erase", 32'(cfg_q), 32'h7FFF);
    @(negedge clk); ers_blk = 1'b1; ers_idx = 3'd3; cfg_we = 1'b1; cfg_wdata = 15'h0;
    @(negedge clk); ers_blk = 1'b0; cfg_we = 1'b0;
    exp_q = blk_mask(3);
    chk("R6 erase beats same-cycle write", 32'(cfg_q), 32'(exp_q));

    // R7 external-access bits
    erase_chip();
    cfg_write(15'h03FF);
    access(1'b0, 24'h000010, 24'h00C000);
    access(1'b1, 24'h000010, 24'h00C000);
    @(negedge clk); ext_addr = 24'h000010; ext_rd = 1'b1; ext_wr = 1'b1;
    #1;
    chk("R7 external read blocked", 32'(ext_rd_ok), 32'h0);
    chk("R7 external write blocked", 32'(ext_wr_ok), 32'h0);
    @(negedge clk); ext_addr = 24'h010000;
    #1;
    chk("R7 external read outside regions", 32'(ext_rd_ok), 32'h1);
    chk("R7 external write outside regions", 32'(ext_wr_ok), 32'h1);
    @(negedge clk); ext_rd = 1'b0; ext_wr = 1'b0;
    erase_chip();
    @(negedge clk); ext_addr = 24'h000010; ext_rd = 1'b1;
    #1;
    chk("R7 external read after erase", 32'(ext_rd_ok), 32'h1);
    @(negedge clk); ext_rd = 1'b0;

    // R8 pulse width
    cfg_write(15'h7FE0);
    access(1'b1, 24'h004000, 24'h004000);
    @(negedge clk);
    chk("R8 error pulse ends", 32'(wr_err), 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule